// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block is a barrier shared by a fixed number of participants. A participant flips its local sense bit, then sends a one-cycle arrive pulse with the flipped bit. The unit counts arrivals in a single serialized counter, so no software lock is needed around the counter. When the last participant of an episode arrives, the counter wraps to zero and the global release flag takes the arriving sense value. Every participant that has arrived and is waiting sees its done output go high in the following cycle.

Because each episode uses the opposite sense value from the one before, the unit needs no separate phase to clear the counter between barriers. A participant may arrive for the next episode in the same cycle that its done output is high. A participant that arrives again while it is already counted and not yet released is ignored, and the unit reports this on an error output.

Top module: `sense_barrier`

## Requirements
- R1: After reset the arrival count is 0, the release flag is 0, and all done bits and the error output are 0.
- R2: An accepted arrival raises `arrival_count_o` by one in the cycle after the arrive pulse.
- R3: All arrivals accepted in the same cycle are counted together in that cycle.
- R4: When the count plus the accepted arrivals of a cycle reaches NUM_PARTS, the count returns to 0 in the next cycle. In that same cycle `release_o` takes the sense bit of the lowest-numbered participant that arrived in the completing cycle. The release flag changes at no other time.
- R5: `done_o[i]` is 1 for exactly one cycle, the cycle after the completing arrival, and it is 1 for every participant counted in that episode.
- R6: A participant that has arrived but is not last keeps `done_o[i]` at 0 while it waits.
- R7: An arrive pulse from a participant that is waiting and not done is ignored: the count and the sense bit stay unchanged. `error_o` is 1 for one cycle in the next cycle.
- R8: An arrive pulse in the cycle where the participant's `done_o` is 1 is accepted as the first arrival of the next episode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arrive_i | input | NUM_PARTS | One-cycle arrival pulse per participant |
| sense_i | input | NUM_PARTS | Local sense bit of each participant, sampled with its arrival |
| done_o | output | NUM_PARTS | Participant may leave the barrier |
| release_o | output | 1 | Global release flag |
| arrival_count_o | output | CNT_W | Arrivals counted in the current episode |
| error_o | output | 1 | Duplicate arrival seen in the previous cycle |

## Verification
The hardest case to reach is a cycle in which several things happen at once: one participant completes an episode, others arrive together with it, and a released participant arrives again in its done cycle while a duplicate comes from someone still waiting. Directed steps set up each of these cases in isolation. Random arrivals then arrive with high probability, so that completions and re-arrivals in done cycles occur often. A share of those random pulses comes from participants that are still waiting, which produces duplicates in every phase of an episode.

// File: rtl/sbar_pkg.sv
package sbar_pkg;

    // Bits needed to hold the values 0..n
    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sbar_gate.sv
// Per-participant arrival qualification.
module sbar_gate (
    input  logic arrive_i,
    input  logic waiting_q_i,
    input  logic sense_q_i,
    input  logic release_q_i,
    output logic done_o,
    output logic accept_o,
    output logic dup_o
);
    always_comb begin
        done_o   = waiting_q_i && (sense_q_i == release_q_i);
        accept_o = arrive_i && (!waiting_q_i || done_o);
        dup_o    = arrive_i && waiting_q_i && !done_o;
    end
endmodule

// File: rtl/sbar_tally.sv
// Serialized arrival counter with completion detection and release selection.
module sbar_tally #(
    parameter int unsigned NUM_PARTS = 4,
    parameter int unsigned CNT_W     = 3,
    parameter int unsigned SUM_W     = 3
) (
    input  logic [NUM_PARTS-1:0] accept_i,
    input  logic [NUM_PARTS-1:0] sense_i,
    input  logic [CNT_W-1:0]     count_q_i,
    input  logic                 release_q_i,
    output logic [CNT_W-1:0]     count_d_o,
    output logic                 release_d_o,
    output logic                 complete_o
);
    logic [SUM_W-1:0] sum;
    logic             pick;

    always_comb begin
        sum = SUM_W'(count_q_i);
        for (int i = 0; i < NUM_PARTS; i++) begin
            sum = sum + SUM_W'(accept_i[i]);
        end
        pick = release_q_i;
        for (int i = NUM_PARTS - 1; i >= 0; i--) begin
            if (accept_i[i]) pick = sense_i[i];
        end
        complete_o  = (sum == SUM_W'(NUM_PARTS));
        count_d_o   = complete_o ? '0 : CNT_W'(sum);
        release_d_o = complete_o ? pick : release_q_i;
    end
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier
    import sbar_pkg::*;
#(
    parameter int unsigned NUM_PARTS = 4,
    localparam int unsigned CNT_W    = cnt_width(NUM_PARTS),
    localparam int unsigned SUM_W    = cnt_width(2 * NUM_PARTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PARTS-1:0] arrive_i,
    input  logic [NUM_PARTS-1:0] sense_i,
    output logic [NUM_PARTS-1:0] done_o,
    output logic                 release_o,
    output logic [CNT_W-1:0]     arrival_count_o,
    output logic                 error_o
);
    typedef struct packed {
        logic [CNT_W-1:0]     count;
        logic                 rel;
        logic [NUM_PARTS-1:0] sense;
        logic [NUM_PARTS-1:0] waiting;
        logic                 err;
    } bar_state_t;

    bar_state_t st_d, st_q;

    logic [NUM_PARTS-1:0] done_w, accept_w, dup_w;
    logic [CNT_W-1:0]     count_nx;
    logic                 release_nx;
    logic                 complete_w;

    for (genvar g = 0; g < NUM_PARTS; g++) begin : g_slot
        sbar_gate u_gate (
            .arrive_i    (arrive_i[g]),
            .waiting_q_i (st_q.waiting[g]),
            .sense_q_i   (st_q.sense[g]),
            .release_q_i (st_q.rel),
            .done_o      (done_w[g]),
            .accept_o    (accept_w[g]),
            .dup_o       (dup_w[g])
        );
    end

    sbar_tally #(
        .NUM_PARTS (NUM_PARTS),
        .CNT_W     (CNT_W),
        .SUM_W     (SUM_W)
    ) u_tally (
        .accept_i    (accept_w),
        .sense_i     (sense_i),
        .count_q_i   (st_q.count),
        .release_q_i (st_q.rel),
        .count_d_o   (count_nx),
        .release_d_o (release_nx),
        .complete_o  (complete_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.count   = count_nx;
        st_d.rel     = release_nx;
        st_d.sense   = (accept_w & sense_i) | (~accept_w & st_q.sense);
        st_d.waiting = accept_w | (st_q.waiting & ~done_w);
        st_d.err     = |dup_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o          = done_w;
    assign release_o       = st_q.rel;
    assign arrival_count_o = st_q.count;
    assign error_o         = st_q.err;

    // R2: the count never holds a full set of arrivals
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arrival_count_o < CNT_W'(NUM_PARTS));

    // R4: release flag moves only together with a wrap of the count
    p_release_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (release_o != $past(release_o)) |-> (arrival_count_o == '0));

    // R5: done appears only in the cycle right after a wrap
    p_done_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_o) |-> (arrival_count_o == '0));

    // R7: a duplicate arrival is reported in the next cycle
    p_err_follows_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(arrive_i & st_q.waiting & ~done_o)) |=> error_o);

    // R7: a duplicate leaves the count untouched when nobody else arrives
    p_dup_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((arrive_i & ~(st_q.waiting & ~done_o)) == '0) |=> $stable(arrival_count_o));
endmodule

// File: tb/sense_barrier_bench.sv
module sense_barrier_bench;
    localparam int N  = 4;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  arrive = '0;
    logic [N-1:0]  sense = '0;
    logic [N-1:0]  done;
    logic          rel;
    logic [CW-1:0] cnt;
    logic          err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench reference state
    int      m_count = 0;
    bit      m_rel = 0;
    bit [N-1:0] m_wait = '0, m_sense = '0, lsense = '0;
    bit      m_err = 0;

    sense_barrier #(.NUM_PARTS(N)) u_sense_barrier (
        .clk(clk), .rst_n(rst_n), .arrive_i(arrive), .sense_i(sense),
        .done_o(done), .release_o(rel), .arrival_count_o(cnt), .error_o(err)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=200000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit [N-1:0] exp_done();
        bit [N-1:0] d;
        for (int i = 0; i < N; i++) d[i] = m_wait[i] && (m_sense[i] == m_rel);
        return d;
    endfunction

    task automatic compare_all();
        chk(cnt == CW'(m_count), "R2 count", cnt, m_count);
        chk(rel == m_rel, "R4 release", rel, m_rel);
        chk(done == exp_done(), "R5 done", done, exp_done());
        chk(err == m_err, "R7 error", err, m_err);
    endtask

    // Drive one cycle of arrivals (called at a negedge), update the expectation.
    task automatic go(input bit [N-1:0] arr);
        bit [N-1:0] d, acc, dup, s;
        int sum;
        bit pick;
        bit found;
        d = exp_done();
        acc = arr & (~m_wait | d);
        dup = arr & m_wait & ~d;
        s = '0;
        for (int i = 0; i < N; i++) begin
            if (acc[i]) lsense[i] = ~lsense[i];
            s[i] = lsense[i];
        end
        sum = m_count;
        found = 0;
        pick = m_rel;
        for (int i = 0; i < N; i++) begin
            if (acc[i]) begin
                sum++;
                if (!found) begin pick = s[i]; found = 1; end
            end
        end
        if (sum == N) begin m_count = 0; m_rel = pick; end
        else m_count = sum;
        m_sense = (acc & s) | (~acc & m_sense);
        m_wait  = acc | (m_wait & ~d);
        m_err   = |dup;
        arrive = arr;
        sense  = s;
        @(posedge clk);
        @(negedge clk);
        arrive = '0;
        compare_all();
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cnt == 0, "R1 count", cnt, 0);
        chk(rel == 0, "R1 release", rel, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(err == 0, "R1 error", err, 0);

        // R2/R6: one at a time, nobody done yet
        go(4'b0001); chk(cnt == 1, "R2 one", cnt, 1); chk(done == 0, "R6 wait", done, 0);
        go(4'b0010); chk(cnt == 2, "R2 two", cnt, 2); chk(done == 0, "R6 wait", done, 0);
        go(4'b0100); chk(cnt == 3, "R2 three", cnt, 3); chk(done == 0, "R6 wait", done, 0);
        // R4/R5: last arrival completes the episode
        go(4'b1000);
        chk(cnt == 0, "R4 wrap", cnt, 0);
        chk(rel == 1, "R4 release sense", rel, 1);
        chk(done == 4'b1111, "R5 all done", done, 4'b1111);
        go(4'b0000);
        chk(done == 0, "R5 single cycle", done, 0);

        // R3: all arrive together, release flips back to 0
        go(4'b1111);
        chk(cnt == 0, "R3 together wrap", cnt, 0);
        chk(rel == 0, "R3 release", rel, 0);
        chk(done == 4'b1111, "R3 done", done, 4'b1111);

        // R8: re-arrival in the done cycle starts the next episode
        go(4'b0011);
        chk(cnt == 2, "R8 next episode", cnt, 2);
        chk(err == 0, "R8 no error", err, 0);

        // R7: duplicates are ignored and flagged
        go(4'b0011);
        chk(cnt == 2, "R7 ignored", cnt, 2);
        chk(err == 1, "R7 flagged", err, 1);
        go(4'b1100);
        chk(rel == 1, "R4 release again", rel, 1);
        chk(err == 0, "R7 one cycle", err, 0);

        // random traffic, many completions and duplicates
        for (int k = 0; k < 3000; k++) begin
            bit [N-1:0] a;
            for (int i = 0; i < N; i++) a[i] = ($urandom % 100) < 45;
            go(a);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule